// File: doc/BRIEF.md
# Synchronous Clock Stop and Power-Down Controller

This block takes one master clock running at six times the PCI rate and produces three families of divided clocks from it. The first is a pair of CPU clocks at either a third or half of the master rate. The second is a bank of stoppable PCI clocks at a sixth of the master rate. The third is one fixed PCI clock at that same rate, which keeps running through a PCI stop. Every output is a flop driven by the master clock, so all output edges line up with master edges. Each CPU rising edge comes one master cycle before the matching PCI rising edge.

Three active-low controls gate the outputs: a CPU stop, a PCI stop and a power-down. Each one is sampled only at the start of an output cycle. Its effect also begins only at a later cycle start. As a result, a stop never shortens a high phase, and a restart always begins with a full-width high phase. The rate select is captured while reset is asserted, and it stays fixed until the next reset.

Top module: `clkstop_top`

## Requirements
- R1: While `rstN` is low, every clock output is 0.
- R2: The fixed PCI clock has a period of 6 master cycles, high for 3 and low for 3. After reset is released, its first rising edge comes at the second master rising edge. While running, it is high in the master cycles at phases 1, 2 and 3 of a 0..5 phase count, where phase 0 is the first edge after reset.
- R3: When `selFast` was 0 during reset, each running CPU clock has a period of 3 master cycles and is high for 1 of them, rising at phases 0 and 3. When it was 1, the period is 2 master cycles, high for 1, rising at phases 0, 2 and 4.
- R4: While the CPU clocks run, every rising edge of a PCI output comes exactly one master cycle after a CPU rising edge.
- R5: At each CPU cycle start, the AND of `cpuStopN` and `pwrDownN` is sampled. The value sampled at start k decides whether cycle k+2 is driven high or held low. The latency is therefore 2 to 3 CPU cycles in both the stop and the start direction.
- R6: At each fixed-PCI rising edge, the AND of `pciStopN` and `pwrDownN` is sampled. It decides the cycle of the stoppable PCI outputs that begins at the next fixed-PCI cycle start. While stopped, these outputs are 0.
- R7: `pciStopN` has no effect on the fixed PCI clock.
- R8: A low `pwrDownN` stops the CPU clocks through the R5 path and the stoppable PCI clocks through the R6 path. It also stops the fixed PCI clock, which is sampled at the same fixed-PCI edge and takes effect one cycle later. A high `pwrDownN` restarts all of them with full cycles.
- R9: `selFast` is loaded only while `rstN` is low. Changing it while running has no effect on the CPU rate.
- R10: No output shows a runt. Every CPU high phase lasts exactly 1 master cycle. Every PCI high phase lasts exactly 3 master cycles. No low phase is shorter than the nominal low time. All copies within a family are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, six times the PCI rate |
| rstN | input | 1 | Asynchronous active-low reset; also the window in which the rate select is captured |
| selFast | input | 1 | CPU rate select: 0 divides the master clock by 3, 1 divides it by 2 |
| cpuStopN | input | 1 | Active-low CPU clock stop |
| pciStopN | input | 1 | Active-low stop for the stoppable PCI clocks |
| pwrDownN | input | 1 | Active-low power-down of all clock outputs |
| cpuClk | output | NUM_CPU | Gated CPU clock copies |
| pciClk | output | NUM_PCI | Stoppable PCI clock copies |
| pciFixClk | output | 1 | Fixed PCI clock, unaffected by the PCI stop |

## Verification
A CPU stop or start changes the outputs at the second CPU cycle-start edge after the edge that sampled it. A PCI or power-down change on the PCI side shows one fixed-PCI cycle after its sampling edge. Every output flop updates on the master rising edge. The bench keeps a behavioural model that advances on the same rising edge, delays its CPU samples by two cycle starts in a queue and its PCI samples by one cycle start, and compares every output at the following falling edge. The stimulus changes inputs at falling edges at several different offsets from the cycle starts, so both ends of the 2-to-3 cycle window are covered. Phase-length counters on the outputs confirm that no high phase is cut short.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Levels that the control asks the datapath to register at the next edge.
  typedef struct packed {
    logic cpuHi;
    logic pciHi;
    logic fixHi;
  } clkLevels_t;

endpackage

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int MASTER_PER_PCI = 6,
  parameter int STOP_DEPTH     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selFast,
  input  logic       cpuStopN,
  input  logic       pciStopN,
  input  logic       pwrDownN,
  output clkLevels_t lvl
);

  localparam int PH_W     = $clog2(MASTER_PER_PCI);
  localparam int CPU_SLOW = MASTER_PER_PCI / 2;
  localparam int CPU_FAST = MASTER_PER_PCI / 3;
  localparam int PCI_HIGH = MASTER_PER_PCI / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(MASTER_PER_PCI - 1);

  logic [PH_W-1:0]       phase;
  logic [PH_W-1:0]       phaseNext;
  logic                  fastMode;
  logic [STOP_DEPTH-1:0] cpuPipe;   // [0] newest sample, [STOP_DEPTH-1] oldest
  logic                  pciSamp;
  logic                  fixSamp;
  logic                  pciGate;
  logic                  fixGate;
  logic                  cpuStart;
  logic                  pciStart;
  logic                  pciWin;

  // Phase of the master clock within one PCI period, as seen after the next edge.
  always_comb begin
    phaseNext = (phase == PH_LAST) ? '0 : phase + PH_W'(1);
    if (fastMode) begin
      cpuStart = (phaseNext % PH_W'(CPU_FAST)) == '0;
    end else begin
      cpuStart = (phaseNext % PH_W'(CPU_SLOW)) == '0;
    end
    pciStart = phaseNext == PH_W'(1);
    pciWin   = (phaseNext >= PH_W'(1)) && (phaseNext <= PH_W'(PCI_HIGH));
  end

  // The rate select is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastMode <= selFast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_LAST;
      cpuPipe <= '1;
      pciSamp <= 1'b1;
      fixSamp <= 1'b1;
      pciGate <= 1'b1;
      fixGate <= 1'b1;
    end else begin
      phase <= phaseNext;
      if (cpuStart) begin
        cpuPipe[0] <= cpuStopN & pwrDownN;
        for (int i = 1; i < STOP_DEPTH; i++) begin
          cpuPipe[i] <= cpuPipe[i-1];
        end
      end
      if (pciStart) begin
        pciGate <= pciSamp;
        fixGate <= fixSamp;
        pciSamp <= pciStopN & pwrDownN;
        fixSamp <= pwrDownN;
      end
    end
  end

  // The CPU high phase is one master cycle at each cycle start, so its gate
  // is the oldest pipeline stage read on the start edge only.
  // The PCI gates switch only at a cycle start, while the PCI output is low.
  always_comb begin
    lvl.cpuHi = cpuStart & cpuPipe[STOP_DEPTH-1];
    lvl.pciHi = pciWin & (pciStart ? pciSamp : pciGate);
    lvl.fixHi = pciWin & (pciStart ? fixSamp : fixGate);
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(fastMode)) else $error("rate select changed while running"); // R9

  AST_PCI_GATE_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    !pciStart |=> $stable(pciGate)) else $error("PCI gate moved mid-cycle"); // R6

endmodule

// File: rtl/clkstop_dp.sv
module clkstop_dp
  import clkstop_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_PCI = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  clkLevels_t         lvl,
  output logic [NUM_CPU-1:0] cpuClk,
  output logic [NUM_PCI-1:0] pciClk,
  output logic               pciFixClk
);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cpuClk[c] <= 1'b0;
      else       cpuClk[c] <= lvl.cpuHi;
    end
  end

  for (genvar p = 0; p < NUM_PCI; p++) begin : g_pci
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pciClk[p] <= 1'b0;
      else       pciClk[p] <= lvl.pciHi;
    end

    AST_PCI_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
      pciClk[p] |-> pciFixClk) else $error("stoppable PCI high while fixed low"); // R6
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pciFixClk <= 1'b0;
    else       pciFixClk <= lvl.fixHi;
  end

  AST_CPU_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClk[0]) |=> !cpuClk[0]) else $error("CPU high phase wrong"); // R10

  AST_FIX_HIGH3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pciFixClk) |=> pciFixClk ##1 pciFixClk ##1 !pciFixClk) else $error("fixed PCI high phase wrong"); // R2

  AST_PCI_HIGH3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pciClk[0]) |=> pciClk[0] ##1 pciClk[0] ##1 !pciClk[0]) else $error("PCI high phase cut"); // R10

endmodule

// File: rtl/clkstop_top.sv
module clkstop_top
  import clkstop_pkg::*;
#(
  parameter int NUM_CPU        = 2,
  parameter int NUM_PCI        = 5,
  parameter int MASTER_PER_PCI = 6,
  parameter int STOP_DEPTH     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selFast,
  input  logic               cpuStopN,
  input  logic               pciStopN,
  input  logic               pwrDownN,
  output logic [NUM_CPU-1:0] cpuClk,
  output logic [NUM_PCI-1:0] pciClk,
  output logic               pciFixClk
);

  clkLevels_t lvl;

  clkstop_ctrl #(
    .MASTER_PER_PCI(MASTER_PER_PCI),
    .STOP_DEPTH    (STOP_DEPTH)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .selFast (selFast),
    .cpuStopN(cpuStopN),
    .pciStopN(pciStopN),
    .pwrDownN(pwrDownN),
    .lvl     (lvl)
  );

  clkstop_dp #(
    .NUM_CPU(NUM_CPU),
    .NUM_PCI(NUM_PCI)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lvl      (lvl),
    .cpuClk   (cpuClk),
    .pciClk   (pciClk),
    .pciFixClk(pciFixClk)
  );

endmodule

// File: tb/sim_clkstop_top.sv
module sim_clkstop_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selFast = 1'b0;
  logic cpuStopN = 1'b1;
  logic pciStopN = 1'b1;
  logic pwrDownN = 1'b1;
  logic [NC-1:0] cpuClk;
  logic [NP-1:0] pciClk;
  logic pciFixClk;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  clkstop_top #(.NUM_CPU(NC), .NUM_PCI(NP)) u0 (
    .clk(clk), .rstN(rstN), .selFast(selFast), .cpuStopN(cpuStopN),
    .pciStopN(pciStopN), .pwrDownN(pwrDownN),
    .cpuClk(cpuClk), .pciClk(pciClk), .pciFixClk(pciFixClk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase within the PCI period, CPU samples delayed
  // by two CPU cycle starts, PCI samples delayed by one PCI cycle start.
  int ph;
  bit mFast;
  bit cq[$];
  bit pS, fS, pG, fG;
  bit eCpu, ePci, eFix;
  bit startNow;
  bit gNow;

  always @(posedge clk) begin
    if (!rstN) begin
      mFast = selFast;
      ph = 5;
      cq = {1'b1, 1'b1};
      pS = 1; fS = 1; pG = 1; fG = 1;
      eCpu = 0; ePci = 0; eFix = 0;
    end else begin
      ph = (ph + 1) % 6;
      startNow = mFast ? (ph % 2 == 0) : (ph % 3 == 0);
      eCpu = 0;
      if (startNow) begin
        gNow = cq.pop_front();
        cq.push_back(cpuStopN & pwrDownN);
        eCpu = gNow;
      end
      if (ph == 1) begin
        pG = pS; fG = fS;
        pS = pciStopN & pwrDownN;
        fS = pwrDownN;
      end
      ePci = (ph >= 1 && ph <= 3) && pG;
      eFix = (ph >= 1 && ph <= 3) && fG;
    end
  end

  // Per-cycle comparison and phase-length measurement on the falling edge.
  bit prevCpu, prevFix, prevPci, cpuRosePrev, leadArm, seen;
  int cpuHiLen, cpuLoLen, fixHiLen, pciHiLen, fixRises, pciRises;

  always @(negedge clk) begin
    if (rstN) begin
      chk(cpuClk === {NC{eCpu}}, curReq, "cpuClk", int'(cpuClk), eCpu ? 3 : 0);
      chk(pciClk === {NP{ePci}}, curReq, "pciClk", int'(pciClk), ePci ? 31 : 0);
      chk(pciFixClk === eFix, curReq, "pciFixClk", int'(pciFixClk), int'(eFix));
      // R10: high phases exact, low phases not short
      if (cpuClk[0]) begin
        if (!prevCpu && seen) chk(cpuLoLen >= (mFast ? 1 : 2), "R10", "cpu low len", cpuLoLen, mFast ? 1 : 2);
        cpuHiLen++; cpuLoLen = 0; seen = 1;
      end else begin
        if (prevCpu) chk(cpuHiLen == 1, "R10", "cpu high len", cpuHiLen, 1);
        cpuHiLen = 0; cpuLoLen++;
      end
      if (pciFixClk) fixHiLen++;
      else begin
        if (prevFix) chk(fixHiLen == 3, "R2", "fixed high len", fixHiLen, 3);
        fixHiLen = 0;
      end
      if (pciClk[0]) pciHiLen++;
      else begin
        if (prevPci) chk(pciHiLen == 3, "R10", "pci high len", pciHiLen, 3);
        pciHiLen = 0;
      end
      // R4: PCI rise one master cycle after a CPU rise
      if (pciFixClk && !prevFix) begin
        fixRises++;
        if (leadArm) chk(cpuRosePrev, "R4", "cpu rise before pci rise", int'(cpuRosePrev), 1);
      end
      if (pciClk[0] && !prevPci) pciRises++;
      cpuRosePrev = cpuClk[0] && !prevCpu;
      prevCpu = cpuClk[0]; prevFix = pciFixClk; prevPci = pciClk[0];
    end else begin
      prevCpu = 0; prevFix = 0; prevPci = 0; cpuRosePrev = 0;
      cpuHiLen = 0; cpuLoLen = 0; fixHiLen = 0; pciHiLen = 0; seen = 0;
    end
  end

  task automatic doReset(input bit fast);
    @(negedge clk);
    rstN = 0; selFast = fast;
    cpuStopN = 1; pciStopN = 1; pwrDownN = 1;
    repeat (4) @(negedge clk);
    chk(cpuClk == '0 && pciClk == '0 && !pciFixClk, "R1", "outputs in reset",
        int'({cpuClk, pciClk, pciFixClk}), 0);
    rstN = 1;
  endtask

  task automatic cpuStopRun(input int offs);
    curReq = "R5";
    repeat (offs) @(negedge clk);
    cpuStopN = 0;
    repeat (13) @(negedge clk);
    cpuStopN = 1;
    repeat (12 + offs) @(negedge clk);
  endtask

  task automatic modeRun(input bit fast);
    doReset(fast);
    curReq = "R3";
    repeat (2) @(negedge clk);
    chk(pciFixClk == 1'b1, "R2", "first fixed rise at 2nd edge", int'(pciFixClk), 1);
    leadArm = 1;
    repeat (30) @(negedge clk);
    leadArm = 0;
    for (int o = 0; o < 3; o++) cpuStopRun(o);
    // R6 and R7: PCI stop held, then brief pulses at different offsets
    curReq = "R6";
    pciStopN = 0;
    repeat (8) @(negedge clk);
    fixRises = 0; pciRises = 0;
    repeat (24) @(negedge clk);
    chk(pciRises == 0, "R6", "pci rises while stopped", pciRises, 0);
    chk(fixRises == 4, "R7", "fixed rises during pci stop", fixRises, 4);
    pciStopN = 1;
    repeat (14) @(negedge clk);
    for (int o = 0; o < 6; o++) begin
      curReq = "R6";
      pciStopN = 0;
      repeat (o + 1) @(negedge clk);
      pciStopN = 1;
      repeat (13) @(negedge clk);
    end
    // R8: power-down stops everything, then restarts
    curReq = "R8";
    pwrDownN = 0;
    repeat (14) @(negedge clk);
    fixRises = 0; pciRises = 0;
    repeat (18) @(negedge clk);
    chk(fixRises == 0 && pciRises == 0 && cpuClk == '0, "R8", "rises during power-down",
        fixRises + pciRises, 0);
    pwrDownN = 1;
    repeat (20) @(negedge clk);
    // R9: flipping the select while running changes nothing
    curReq = "R9";
    selFast = !fast;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    modeRun(1'b0);
    modeRun(1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule